// File: doc/BRIEF.md
# Debug Scan-Chain Register Access Controller

This block sits between a debug host and the rest of a processor subsystem and steers every register read or write the host issues to one of four targets. A select command picks the active target: the CPU special-register file, a trace chain, a local bank of development-interface registers, or the system memory bus. Read and write commands then go to that target and carry an address and write data. Each command gets back an error code and, for reads, data.

The development-interface bank sits inside the block. It holds mode, trigger-select, qualifier-select and stop-select words, a run-control word, eleven watchpoint record words and one breakpoint record word. Two bits of the run-control word drive the processor. Bit 0 holds the system in reset while it is set and fires a one-cycle system reset pulse when it is cleared. Bit 1 requests a CPU stall, which is suppressed whenever the CPU reports that its debugger is disabled. The CPU register file and the memory are external and are reached through plain strobe ports. Memory accesses are checked against a fixed valid window.

Every command is accepted in the cycle `cmd_valid` is high. Its response appears in the following cycle for exactly one cycle, with `rsp_done`, `rsp_err` and `rsp_rdata` valid together.

Top module: `dbg_chain_router`

## Requirements
- R1: A select command (cmd_op=0) takes the chain number from cmd_addr. The values 0 (CPU registers), 1 (trace), 2 (development interface) and 3 (memory) become the active chain and return error 0. Any other value returns error 1 (bad chain) and leaves the active chain unchanged.
- R2: A command accepted in one cycle raises rsp_done in the next cycle only, with rsp_err and rsp_rdata valid in that cycle. rsp_done is low after a cycle without cmd_valid. Write, select and no-op (cmd_op=3) responses carry data 0. A no-op returns error 0 and has no effect.
- R3: On chain 0, a read (cmd_op=1) pulses spr_re and returns spr_rdata with error 0. A write (cmd_op=2) pulses spr_we and drives cmd_addr and cmd_wdata onto spr_addr and spr_wdata.
- R4: On chain 1, a read returns data 0 with error 0. A write returns error 3 (access exception) and raises no external write strobe.
- R5: On chain 2, addresses 0..3 hold the mode, trigger-select, qualifier-select and stop-select words, 4 holds run control, 5..15 hold the eleven watchpoint records and 16 holds the breakpoint record. A read returns the last value written to that address.
- R6: On chain 2, an address above 16 returns error 2 (bad address). A read at such an address returns data 0, and a write changes no register.
- R7: du_in_reset equals bit 0 of the run-control word. A run-control write that changes bit 0 from 1 to 0 raises sys_reset_pulse for one cycle, in the same cycle as that write's rsp_done.
- R8: cpu_stall follows bit 1 of the last run-control write, but is low in every cycle that cpu_dbg_disable is high.
- R9: On chain 3, an address in [MEM_BASE, MEM_BASE+MEM_WORDS) reads mem_rdata or writes through mem_we. Any other address returns error 2, reads data 0 and raises no mem_we.
- R10: The debug-unit reset clears all development-interface registers, deasserts stall and reset pulse, and selects chain 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high debug-unit reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 select, 1 read, 2 write, 3 no-op |
| cmd_addr | input | AW | Register address, or chain number for select |
| cmd_wdata | input | DW | Write data |
| rsp_done | output | 1 | Response valid (one cycle after the command) |
| rsp_err | output | 2 | 0 ok, 1 bad chain, 2 bad address, 3 access exception |
| rsp_rdata | output | DW | Read data |
| spr_re | output | 1 | CPU register read strobe |
| spr_we | output | 1 | CPU register write strobe |
| spr_addr | output | AW | CPU register address |
| spr_wdata | output | DW | CPU register write data |
| spr_rdata | input | DW | CPU register read data (combinational) |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data (combinational) |
| cpu_dbg_disable | input | 1 | CPU reports debugger disabled |
| cpu_stall | output | 1 | Stall request to the CPU |
| du_in_reset | output | 1 | Run-control reset bit is set |
| sys_reset_pulse | output | 1 | One-cycle system reset on release of the reset bit |

## Verification
Directed sequences walk every chain with reads, writes, an out-of-range chain number and addresses just inside and outside the development-interface bank and the memory window. These show whether each target decodes its own boundary. A run-control sequence of 1 then 2, with the debugger-disable input toggled, separates the reset-release pulse from the stall path and its masking. Random commands, with a fixed seed, mix all four operations and address pools around both boundaries. They check that the selection survives bad selects and that written state is read back unchanged across chains. A reset in the middle of the run checks that every register returns to its cleared value.

// File: rtl/dbg_chain_pkg.sv
`timescale 1ns/1ps
package dbg_chain_pkg;

    localparam int CHAIN_W = 4;

    typedef enum logic [1:0] {
        OP_SEL = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_NOP = 2'd3
    } dbg_op_e;

    typedef enum logic [CHAIN_W-1:0] {
        CH_CPU    = 4'd0,
        CH_TRACE  = 4'd1,
        CH_DEVINT = 4'd2,
        CH_MEM    = 4'd3
    } chain_e;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_BAD_CHAIN = 2'd1,
        ERR_BAD_ADDR  = 2'd2,
        ERR_ACCESS    = 2'd3
    } dbg_err_e;

    // development-interface word addresses
    localparam int DI_MODE    = 0;
    localparam int DI_TRIG    = 1;
    localparam int DI_QUAL    = 2;
    localparam int DI_STOP    = 3;
    localparam int DI_RUNCTL  = 4;
    localparam int DI_WP_BASE = 5;
    localparam int DI_WP_NUM  = 11;

    // run-control bit positions
    localparam int RC_RESET_BIT = 0;
    localparam int RC_STALL_BIT = 1;

    typedef struct packed {
        logic     done;
        dbg_err_e err;
    } dbg_rsp_t;

endpackage

// File: rtl/dbg_mem_gate.sv
`timescale 1ns/1ps
module dbg_mem_gate #(
    parameter int          AW        = 32,
    parameter int unsigned MEM_BASE  = 32'h100,
    parameter int unsigned MEM_WORDS = 16
) (
    input  logic [AW-1:0] addr,
    output logic          in_range
);
    localparam logic [AW:0] LO = (AW+1)'(MEM_BASE);
    localparam logic [AW:0] HI = (AW+1)'(MEM_BASE) + (AW+1)'(MEM_WORDS);

    logic [AW:0] ext_addr;

    always_comb begin
        ext_addr = {1'b0, addr};
        in_range = (ext_addr >= LO) && (ext_addr < HI);
    end
endmodule

// File: rtl/dbg_devint_regs.sv
`timescale 1ns/1ps
module dbg_devint_regs
    import dbg_chain_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int NWP = DI_WP_NUM
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          addr_ok,
    output logic          run_reset,
    output logic          run_stall,
    output logic          rst_pulse
);
    localparam int BP_ADDR = DI_WP_BASE + NWP;

    logic [DW-1:0] mode_q, trig_q, qual_q, stop_q, run_q, bp_q;
    logic [DW-1:0] wp_rd [NWP];
    logic          run_wr;

    assign run_wr = wr_en && (addr == AW'(DI_RUNCTL));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            trig_q    <= '0;
            qual_q    <= '0;
            stop_q    <= '0;
            run_q     <= '0;
            bp_q      <= '0;
            rst_pulse <= 1'b0;
        end else begin
            if (wr_en && addr == AW'(DI_MODE)) mode_q <= wdata;
            if (wr_en && addr == AW'(DI_TRIG)) trig_q <= wdata;
            if (wr_en && addr == AW'(DI_QUAL)) qual_q <= wdata;
            if (wr_en && addr == AW'(DI_STOP)) stop_q <= wdata;
            if (wr_en && addr == AW'(BP_ADDR)) bp_q   <= wdata;
            if (run_wr) run_q <= wdata;
            rst_pulse <= run_wr && run_q[RC_RESET_BIT] && !wdata[RC_RESET_BIT];
        end
    end

    for (genvar g = 0; g < NWP; g++) begin : g_wp
        logic [DW-1:0] wp_q;
        always_ff @(posedge clk) begin
            if (rst)
                wp_q <= '0;
            else if (wr_en && addr == AW'(DI_WP_BASE + g))
                wp_q <= wdata;
        end
        assign wp_rd[g] = wp_q;
    end

    always_comb begin
        addr_ok = 1'b1;
        rdata   = '0;
        if      (addr == AW'(DI_MODE))   rdata = mode_q;
        else if (addr == AW'(DI_TRIG))   rdata = trig_q;
        else if (addr == AW'(DI_QUAL))   rdata = qual_q;
        else if (addr == AW'(DI_STOP))   rdata = stop_q;
        else if (addr == AW'(DI_RUNCTL)) rdata = run_q;
        else if (addr == AW'(BP_ADDR))   rdata = bp_q;
        else begin
            addr_ok = 1'b0;
            for (int i = 0; i < NWP; i++) begin
                if (addr == AW'(DI_WP_BASE + i)) begin
                    addr_ok = 1'b1;
                    rdata   = wp_rd[i];
                end
            end
        end
    end

    assign run_reset = run_q[RC_RESET_BIT];
    assign run_stall = run_q[RC_STALL_BIT];

    // R7: the pulse only follows a release of the reset bit
    p_pulse_on_release_r7: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |-> $fell(run_q[RC_RESET_BIT]));

    // R10: reset clears run control
    p_run_cleared_r10: assert property (@(posedge clk)
        rst |=> (run_q == '0 && !rst_pulse));
endmodule

// File: rtl/dbg_chain_router.sv
`timescale 1ns/1ps
module dbg_chain_router
    import dbg_chain_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          DW        = 32,
    parameter int unsigned MEM_BASE  = 32'h100,
    parameter int unsigned MEM_WORDS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          rsp_done,
    output logic [1:0]    rsp_err,
    output logic [DW-1:0] rsp_rdata,
    output logic          spr_re,
    output logic          spr_we,
    output logic [AW-1:0] spr_addr,
    output logic [DW-1:0] spr_wdata,
    input  logic [DW-1:0] spr_rdata,
    output logic          mem_re,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          cpu_dbg_disable,
    output logic          cpu_stall,
    output logic          du_in_reset,
    output logic          sys_reset_pulse
);
    dbg_op_e       op;
    chain_e        sel_q;
    dbg_rsp_t      rsp_q, rsp_nx;
    logic [DW-1:0] rdata_q, rdata_nx;
    logic          is_rd, is_wr, chain_ok, mem_ok;
    logic          di_ok, di_wr, run_stall;
    logic [DW-1:0] di_rdata;

    assign op       = dbg_op_e'(cmd_op);
    assign is_rd    = cmd_valid && (op == OP_RD);
    assign is_wr    = cmd_valid && (op == OP_WR);
    assign chain_ok = (cmd_addr <= AW'(CH_MEM));

    dbg_mem_gate #(.AW(AW), .MEM_BASE(MEM_BASE), .MEM_WORDS(MEM_WORDS)) u_gate (
        .addr     (cmd_addr),
        .in_range (mem_ok)
    );

    assign di_wr = is_wr && (sel_q == CH_DEVINT);

    dbg_devint_regs #(.AW(AW), .DW(DW), .NWP(DI_WP_NUM)) u_devint (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (di_wr),
        .addr      (cmd_addr),
        .wdata     (cmd_wdata),
        .rdata     (di_rdata),
        .addr_ok   (di_ok),
        .run_reset (du_in_reset),
        .run_stall (run_stall),
        .rst_pulse (sys_reset_pulse)
    );

    // external strobes
    assign spr_re    = is_rd && (sel_q == CH_CPU);
    assign spr_we    = is_wr && (sel_q == CH_CPU);
    assign spr_addr  = cmd_addr;
    assign spr_wdata = cmd_wdata;
    assign mem_re    = is_rd && (sel_q == CH_MEM) && mem_ok;
    assign mem_we    = is_wr && (sel_q == CH_MEM) && mem_ok;
    assign mem_addr  = cmd_addr;
    assign mem_wdata = cmd_wdata;

    always_comb begin
        rsp_nx.done = cmd_valid;
        rsp_nx.err  = ERR_NONE;
        rdata_nx    = '0;
        unique case (op)
            OP_SEL: if (!chain_ok) rsp_nx.err = ERR_BAD_CHAIN;
            OP_RD, OP_WR: begin
                unique case (sel_q)
                    CH_CPU:    rdata_nx = spr_rdata;
                    CH_TRACE:  if (op == OP_WR) rsp_nx.err = ERR_ACCESS;
                    CH_DEVINT: begin
                        rdata_nx = di_rdata;
                        if (!di_ok) rsp_nx.err = ERR_BAD_ADDR;
                    end
                    CH_MEM: begin
                        if (mem_ok) rdata_nx = mem_rdata;
                        else        rsp_nx.err = ERR_BAD_ADDR;
                    end
                    default:   rsp_nx.err = ERR_BAD_CHAIN;
                endcase
            end
            default: ;
        endcase
        if (op != OP_RD) rdata_nx = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= CH_CPU;
            rsp_q   <= '0;
            rdata_q <= '0;
        end else begin
            rsp_q   <= cmd_valid ? rsp_nx : '0;
            rdata_q <= cmd_valid ? rdata_nx : '0;
            if (cmd_valid && op == OP_SEL && chain_ok)
                sel_q <= chain_e'(cmd_addr[CHAIN_W-1:0]);
        end
    end

    assign rsp_done  = rsp_q.done;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rdata_q;
    assign cpu_stall = run_stall && !cpu_dbg_disable;

    p_done_follows_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_done);
    p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rsp_done);
    p_bad_chain_holds_r1: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_err == ERR_BAD_CHAIN) |-> $stable(sel_q));
    p_trace_write_exc_r4: assert property (@(posedge clk) disable iff (rst)
        (is_wr && sel_q == CH_TRACE) |=> (rsp_err == ERR_ACCESS));
    p_stall_masked_r8: assert property (@(posedge clk) disable iff (rst)
        cpu_dbg_disable |-> !cpu_stall);
    p_mem_bad_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && sel_q == CH_MEM && rsp_err == ERR_BAD_ADDR) |-> (rsp_rdata == '0));
endmodule

// File: tb/dbg_chain_router_tb_top.sv
`timescale 1ns/1ps
module dbg_chain_router_tb_top;
    localparam int MBASE = 32'h100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] cmd_addr = '0, cmd_wdata = '0;
    logic        rsp_done;
    logic [1:0]  rsp_err;
    logic [31:0] rsp_rdata;
    logic        spr_re, spr_we, mem_re, mem_we;
    logic [31:0] spr_addr, spr_wdata, spr_rdata, mem_addr, mem_wdata, mem_rdata;
    logic        dis = 1'b0;
    logic        cpu_stall, du_in_reset, sys_reset_pulse;

    int checks = 0, fails = 0;
    bit fin = 0;

    always #2 clk = ~clk;

    function automatic logic [31:0] spr_f(input logic [31:0] a);
        return (a * 32'h9E37_79B9) ^ 32'h0000_1234;
    endfunction

    assign spr_rdata = spr_f(spr_addr);
    logic [31:0] mdev [16];
    assign mem_rdata = mdev[mem_addr[3:0]];
    always @(posedge clk) if (mem_we) mdev[mem_addr[3:0]] <= mem_wdata;

    dbg_chain_router dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .spr_re(spr_re),
        .spr_we(spr_we), .spr_addr(spr_addr), .spr_wdata(spr_wdata),
        .spr_rdata(spr_rdata), .mem_re(mem_re), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cpu_dbg_disable(dis), .cpu_stall(cpu_stall),
        .du_in_reset(du_in_reset), .sys_reset_pulse(sys_reset_pulse)
    );

    // reference state
    int          sel_m;
    logic [31:0] di_m [17];
    logic [31:0] mref [16];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        sel_m = 0;
        for (int i = 0; i < 17; i++) di_m[i] = '0;
    endtask

    task automatic exec(input logic [1:0] op, input logic [31:0] a, input logic [31:0] w);
        logic [1:0]  e_err;
        logic [31:0] e_data;
        logic        e_pulse, e_sprwe, e_memwe, in_mem;
        logic        s_sprwe, s_memwe;
        logic [31:0] s_spra, s_sprd;
        e_err = 2'd0; e_data = '0; e_pulse = 1'b0;
        in_mem  = (a >= MBASE) && (a < MBASE + 16);
        e_sprwe = (op == 2'd2) && (sel_m == 0);
        e_memwe = (op == 2'd2) && (sel_m == 3) && in_mem;
        // idle cycle before the command: no response, no pulse (R2, R7)
        @(negedge clk);
        chk("R2 idle done", {31'd0, rsp_done}, 32'd0);
        chk("R7 idle pulse", {31'd0, sys_reset_pulse}, 32'd0);
        if (op == 2'd0) begin
            if (a > 3) e_err = 2'd1;
        end else if (op != 2'd3) begin
            case (sel_m)
                0: if (op == 2'd1) e_data = spr_f(a);
                1: if (op == 2'd2) e_err = 2'd3;
                2: begin
                    if (a <= 16) begin
                        if (op == 2'd1) e_data = di_m[a];
                        else if (a == 4) e_pulse = di_m[4][0] && !w[0];
                    end else e_err = 2'd2;
                end
                default: begin
                    if (in_mem) begin
                        if (op == 2'd1) e_data = mref[a - MBASE];
                    end else e_err = 2'd2;
                end
            endcase
        end
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = w;
        #1;
        s_sprwe = spr_we; s_memwe = mem_we; s_spra = spr_addr; s_sprd = spr_wdata;
        @(negedge clk);
        cmd_valid = 1'b0;
        // state updates of the reference
        if (op == 2'd0 && a <= 3) sel_m = int'(a);
        if (op == 2'd2 && sel_m == 2 && a <= 16) di_m[a] = w;
        if (op == 2'd2 && sel_m == 3 && in_mem) mref[a - MBASE] = w;
        chk("R2 done", {31'd0, rsp_done}, 32'd1);
        chk((op == 2'd0) ? "R1 select err" : (sel_m == 1) ? "R4 trace err" :
            (sel_m == 2) ? "R6 devint err" : (sel_m == 3) ? "R9 mem err" : "R3 cpu err",
            {30'd0, rsp_err}, {30'd0, e_err});
        chk((sel_m == 2) ? "R5 devint data" : (sel_m == 3) ? "R9 mem data" :
            (sel_m == 1) ? "R4 trace data" : "R3 data", rsp_rdata, e_data);
        chk("R3 spr_we strobe", {31'd0, s_sprwe}, {31'd0, e_sprwe});
        if (e_sprwe) begin
            chk("R3 spr_addr", s_spra, a);
            chk("R3 spr_wdata", s_sprd, w);
        end
        chk("R9 mem_we strobe", {31'd0, s_memwe}, {31'd0, e_memwe});
        chk("R7 reset pulse", {31'd0, sys_reset_pulse}, {31'd0, e_pulse});
        chk("R7 in reset", {31'd0, du_in_reset}, {31'd0, di_m[4][0]});
        chk("R8 stall", {31'd0, cpu_stall}, {31'd0, di_m[4][1] && !dis});
    endtask

    task automatic check_reset_state();
        chk("R10 done", {31'd0, rsp_done}, 32'd0);
        chk("R10 err", {30'd0, rsp_err}, 32'd0);
        chk("R10 stall", {31'd0, cpu_stall}, 32'd0);
        chk("R10 in reset", {31'd0, du_in_reset}, 32'd0);
        chk("R10 pulse", {31'd0, sys_reset_pulse}, 32'd0);
    endtask

    initial begin
        #800000;
        if (!fin) begin
            fails++;
            $display("FAIL R2 watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) begin mdev[i] = 32'h5A00_0000 + i; mref[i] = 32'h5A00_0000 + i; end
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset_state();

        // R3 CPU chain (default after reset)
        exec(2'd1, 32'h40, 0);
        exec(2'd2, 32'h41, 32'hCAFE_0001);
        // R1 bad chain keeps CPU chain
        exec(2'd0, 32'd7, 0);
        exec(2'd0, 32'h1_0002, 0);
        exec(2'd1, 32'h44, 0);
        // R4 trace
        exec(2'd0, 32'd1, 0);
        exec(2'd1, 32'h10, 0);
        exec(2'd2, 32'h10, 32'h1111);
        // R5 / R6 development interface
        exec(2'd0, 32'd2, 0);
        for (int i = 0; i <= 16; i++) if (i != 4) exec(2'd2, i, 32'hD000_0000 + i);
        for (int i = 0; i <= 16; i++) exec(2'd1, i, 0);
        exec(2'd1, 32'd17, 0);
        exec(2'd2, 32'd17, 32'hFFFF_FFFF);
        exec(2'd1, 32'd16, 0);
        // R7 / R8 run control
        exec(2'd2, 32'd4, 32'h1);
        exec(2'd2, 32'd4, 32'h2);
        dis = 1'b1;
        exec(2'd3, 32'd0, 0);
        dis = 1'b0;
        exec(2'd3, 32'd0, 0);
        exec(2'd2, 32'd4, 32'h0);
        // R9 memory window edges
        exec(2'd0, 32'd3, 0);
        exec(2'd2, MBASE, 32'hAAAA_0000);
        exec(2'd2, MBASE + 15, 32'hAAAA_000F);
        exec(2'd2, MBASE + 16, 32'hBAD0_0001);
        exec(2'd2, MBASE - 1, 32'hBAD0_0002);
        exec(2'd1, MBASE, 0);
        exec(2'd1, MBASE + 15, 0);
        exec(2'd1, MBASE + 16, 0);

        // random phase
        for (int n = 0; n < 600; n++) begin
            logic [1:0]  op;
            logic [31:0] a;
            op = 2'($urandom % 4);
            case ($urandom % 4)
                0: a = $urandom % 21;
                1: a = 32'hF8 + ($urandom % 32);
                2: a = $urandom % 6;
                default: a = $urandom;
            endcase
            if (op == 2'd0 && ($urandom % 4) != 0) a = $urandom % 6;
            dis = (($urandom % 5) == 0);
            exec(op, a, $urandom);
        end

        // R10 reset mid-run
        @(negedge clk);
        dis = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_reset_state();
        exec(2'd1, 32'h50, 0);
        exec(2'd0, 32'd2, 0);
        exec(2'd1, 32'd4, 0);
        exec(2'd1, 32'd9, 0);

        fin = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule